// File: doc/BRIEF.md
# Prescaled Eight-Bit Event Timer with Pin Output

This block is an 8-bit up-counter for a small nibble-oriented microcontroller. Its count clock comes from one of seven taps of a free-running 11-bit divider, which runs on the instruction cycle, or from rising edges on an external event pin. On an overflow from 0xFF it either wraps to zero or reloads a value that software wrote earlier, and it raises a one-cycle overflow pulse. A shared output pin can carry a plain port level, a level that toggles on every overflow, or a forced 0 or 1.

Software sets the block up through four write-only nibble registers. All of them share a single write strobe, a 2-bit register address and a 4-bit data bus. No data streams through the block, so every pin is plain control or status with no valid/ready handshake. A write is taken in the cycle where the strobe is high, and it cannot be refused. Changes to the timer mode are deliberately delayed. Writing the upper load nibble starts the timer from the full 8-bit load value.

Top module: `prescaled_timer8`

## Requirements
- R1: After reset the count is 0x00, the overflow pulse is low, the mode register is 0 and the output selection is 0, so the pin follows the port input.
- R2: The mode register is address 0. Its bits [2:0] pick the count clock, with a tick every 2048, 512, 128, 32, 8, 4 or 2 cycles for codes 0 to 6. The count rises by one per tick.
- R3: Mode code 7 counts the external event input instead. The event input passes through two synchronising flops, and each rising edge adds exactly one to the count.
- R4: In free-running mode (mode bit 3 = 0), a tick at 0xFF takes the count to 0x00. One cycle later the overflow output is high for exactly one cycle.
- R5: In reload mode (mode bit 3 = 1), a tick at 0xFF loads the count with the stored 8-bit load value and raises the same overflow pulse.
- R6: Address 2 stores the lower load nibble and leaves the count unchanged. Address 3 stores the upper nibble and puts {upper, lower} into the count on the next edge. The lower nibble resets to 0. The upper nibble has no defined reset value.
- R7: A mode write does not change counting behaviour in the cycle after the write. It takes effect from the second cycle after the write.
- R8: The output selection register is address 1, bits [1:0]. Code 00 passes the port input to the pin, 01 drives the toggle level, 10 drives 0 and 11 drives 1. A new selection applies at once.
- R9: The toggle level is 0 after reset and inverts once on each overflow.
- R10: A prescaler tick or an event tick never lasts more than one cycle, and an overflow pulse is never longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 mode, 1 output select, 2 load low, 3 load high |
| wr_data_i | input | 4 | Register write nibble |
| evt_i | input | 1 | External event input, asynchronous |
| port_i | input | 1 | Port level passed to the pin in port mode |
| pin_o | output | 1 | Shared output pin |
| cnt_o | output | 8 | Current count |
| ovf_o | output | 1 | One-cycle overflow pulse |

## Verification
Several properties are checked on every clock cycle: the overflow pulse only follows a count of 0xFF and lands on zero or the reload value, an upper-nibble write puts the assembled value into the count, the toggle level only flips after an overflow, ticks never last two cycles, and the active mode only changes two cycles after a mode write. Other behaviour only shows up in the bench's scenarios: the actual period of each prescaler tap, one count per event edge across several pulses, the decode of the pin selection, and the exact cycle in which a delayed mode write first moves the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DIV_W = 11;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    PIN_PORT   = 2'b00,
    PIN_TOGGLE = 2'b01,
    PIN_LOW    = 2'b10,
    PIN_HIGH   = 2'b11
  } pin_mode_e;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_PIN  = 2'd1,
    REG_LDLO = 2'd2,
    REG_LDHI = 2'd3
  } reg_addr_e;

  localparam logic [2:0] TAP_EXT = 3'd7;

  // Low-bit mask of the divider whose all-ones state marks a tick.
  function automatic logic [DIV_W-1:0] tap_mask(input logic [2:0] code);
    logic [DIV_W-1:0] m;
    case (code)
      3'd0:    m = DIV_W'(2047);
      3'd1:    m = DIV_W'(511);
      3'd2:    m = DIV_W'(127);
      3'd3:    m = DIV_W'(31);
      3'd4:    m = DIV_W'(7);
      3'd5:    m = DIV_W'(3);
      3'd6:    m = DIV_W'(1);
      default: m = '0;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] tap_sel_i,
  input  logic       evt_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] div_q;
  logic             s1_q, s2_q, s3_q;
  logic             int_tick, ext_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
    end else begin
      div_q <= div_q + 1'b1;
      s1_q  <= evt_i;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
    end
  end

  always_comb begin
    int_tick = (tap_sel_i != TAP_EXT) && (&(div_q | ~tap_mask(tap_sel_i)));
    ext_tick = (tap_sel_i == TAP_EXT) && s2_q && !s3_q;
    tick_o   = int_tick || ext_tick;
  end

  // R10
  int_tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_tick |=> !int_tick);
  // R10
  ext_tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_tick |=> !ext_tick);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             reload_en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] rel_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap = tick_i && !load_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= wrap;
      if (load_i)
        cnt_q <= load_val_i;
      else if (wrap)
        cnt_q <= reload_en_i ? rel_val_i : '0;
      else if (tick_i)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R4
  ovf_from_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |-> $past(cnt_q) == CNT_MAX);
  // R4
  free_wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !$past(reload_en_i)) |-> cnt_q == '0);
  // R5
  reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && $past(reload_en_i)) |-> cnt_q == $past(rel_val_i));
  // R6
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load_i) |-> cnt_q == $past(load_val_i));
  // R10
  ovf_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> !ovf_q);
endmodule

// File: rtl/tmr_pinout.sv
module tmr_pinout
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ovf_i,
  input  pin_mode_e pin_mode_i,
  input  logic      port_i,
  output logic      pin_o
);
  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tog_q <= 1'b0;
    else if (ovf_i) tog_q <= ~tog_q;
  end

  always_comb begin
    case (pin_mode_i)
      PIN_PORT:   pin_o = port_i;
      PIN_TOGGLE: pin_o = tog_q;
      PIN_LOW:    pin_o = 1'b0;
      default:    pin_o = 1'b1;
    endcase
  end

  // R9
  toggle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_q != $past(tog_q)) |-> $past(ovf_i));
endmodule

// File: rtl/prescaled_timer8.sv
module prescaled_timer8
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [1:0] wr_addr_i,
  input  logic [3:0] wr_data_i,
  input  logic       evt_i,
  input  logic       port_i,
  output logic       pin_o,
  output logic [7:0] cnt_o,
  output logic       ovf_o
);
  localparam int CNT_W = 2 * NIB_W;

  logic [NIB_W-1:0] mode_pend_q, mode_q, ld_lo_q, ld_hi_q;
  logic             pend_v_q;
  pin_mode_e        pin_mode_q;
  logic             mode_wr, pin_wr, lo_wr, hi_wr, tick;

  always_comb begin
    mode_wr = wr_en_i && (wr_addr_i == REG_MODE);
    pin_wr  = wr_en_i && (wr_addr_i == REG_PIN);
    lo_wr   = wr_en_i && (wr_addr_i == REG_LDLO);
    hi_wr   = wr_en_i && (wr_addr_i == REG_LDHI);
  end

  // Mode write is staged one cycle before it becomes active.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_pend_q <= '0;
      pend_v_q    <= 1'b0;
      mode_q      <= '0;
      pin_mode_q  <= PIN_PORT;
      ld_lo_q     <= '0;
    end else begin
      pend_v_q <= mode_wr;
      if (mode_wr)  mode_pend_q <= wr_data_i;
      if (pend_v_q) mode_q      <= mode_pend_q;
      if (pin_wr)   pin_mode_q  <= pin_mode_e'(wr_data_i[1:0]);
      if (lo_wr)    ld_lo_q     <= wr_data_i;
    end
  end

  // Upper load nibble carries no reset value.
  always_ff @(posedge clk) begin
    if (hi_wr) ld_hi_q <= wr_data_i;
  end

  tmr_prescale u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_sel_i (mode_q[2:0]),
    .evt_i     (evt_i),
    .tick_o    (tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .reload_en_i (mode_q[3]),
    .load_i      (hi_wr),
    .load_val_i  ({wr_data_i, ld_lo_q}),
    .rel_val_i   ({ld_hi_q, ld_lo_q}),
    .cnt_o       (cnt_o),
    .ovf_o       (ovf_o)
  );

  tmr_pinout u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovf_i      (ovf_o),
    .pin_mode_i (pin_mode_q),
    .port_i     (port_i),
    .pin_o      (pin_o)
  );

  // R7
  mode_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(mode_wr, 2));
endmodule

// File: tb/prescaled_timer8_tb_top.sv
`timescale 1ns/1ps
module prescaled_timer8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [3:0] wr_data_i = '0;
  logic       evt_i = 1'b0;
  logic       port_i = 1'b1;
  logic       pin_o, ovf_o;
  logic [7:0] cnt_o;

  int tests = 0;
  int fails = 0;
  int ovf_seen = 0;
  logic ovf_prev = 1'b0;
  bit done = 1'b0;

  // {1'b0, sel[2:0], period[11:0]}
  localparam logic [15:0] PRE_VEC [7] = '{
    16'h0800, 16'h1200, 16'h2080, 16'h3020, 16'h4008, 16'h5004, 16'h6002
  };

  always #4 clk = ~clk;

  prescaled_timer8 dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .evt_i(evt_i), .port_i(port_i),
    .pin_o(pin_o), .cnt_o(cnt_o), .ovf_o(ovf_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R10: overflow pulse never seen on two consecutive cycles
  always @(negedge clk) begin
    if (rst_n) begin
      if (ovf_o) ovf_seen++;
      if (ovf_o && ovf_prev) chk(1'b0, "R10", 2, 1);
      ovf_prev = ovf_o;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk); evt_i = 1'b1;
    repeat (2) @(negedge clk);
    evt_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cnt_o == 8'h00, "R1 count", cnt_o, 0);
    chk(ovf_o == 1'b0, "R1 ovf", ovf_o, 0);
    chk(pin_o == 1'b1, "R1 pin follows port", pin_o, 1);

    // R2 tap periods, table driven
    for (int i = 0; i < 7; i++) begin
      wr(2'd0, {1'b0, PRE_VEC[i][14:12]});
      repeat (3) @(negedge clk);
      prev = cnt_o; n = 0;
      while (cnt_o == prev && n < 5000) begin @(negedge clk); n++; end
      prev = cnt_o; n = 0;
      while (cnt_o == prev && n < 5000) begin @(negedge clk); n++; end
      chk(n == int'(PRE_VEC[i][11:0]), "R2 tap period", n, int'(PRE_VEC[i][11:0]));
    end

    // R6 lower nibble stages, upper nibble loads
    wr(2'd0, 4'h7);
    repeat (3) @(negedge clk);
    prev = cnt_o;
    wr(2'd2, 4'h5);
    @(negedge clk);
    chk(cnt_o == prev, "R6 low nibble no load", cnt_o, prev);
    wr(2'd3, 4'hA);
    chk(cnt_o == 8'hA5, "R6 upper load", cnt_o, 8'hA5);

    // R3 each event edge counts once
    pulse(); pulse(); pulse();
    repeat (2) @(negedge clk);
    chk(cnt_o == 8'hA8, "R3 three edges", cnt_o, 8'hA8);

    // R7 mode delay: switch ext -> period 2
    prev = cnt_o;
    wr(2'd0, 4'h6);
    chk(cnt_o == prev, "R7 unchanged after write", cnt_o, prev);
    @(negedge clk);
    chk(cnt_o == prev, "R7 unchanged one cycle later", cnt_o, prev);
    repeat (2) @(negedge clk);
    chk(cnt_o != prev, "R7 active from second cycle", cnt_o, prev + 1);

    // R4 + R9 free-running wrap with toggle output
    wr(2'd0, 4'h7);
    repeat (3) @(negedge clk);
    wr(2'd1, 4'h1);
    chk(pin_o == 1'b0, "R9 toggle starts low", pin_o, 0);
    wr(2'd2, 4'hE); wr(2'd3, 4'hF);
    ovf_seen = 0;
    pulse();
    chk(cnt_o == 8'hFF, "R4 count to FF", cnt_o, 8'hFF);
    chk(ovf_seen == 0, "R4 no early ovf", ovf_seen, 0);
    pulse();
    repeat (2) @(negedge clk);
    chk(cnt_o == 8'h00, "R4 wrap to zero", cnt_o, 0);
    chk(ovf_seen == 1, "R4 one ovf pulse", ovf_seen, 1);
    chk(pin_o == 1'b1, "R9 toggle after ovf", pin_o, 1);

    // R5 reload mode
    wr(2'd0, 4'hF);
    repeat (3) @(negedge clk);
    wr(2'd2, 4'hA); wr(2'd3, 4'hF);
    chk(cnt_o == 8'hFA, "R5 loaded", cnt_o, 8'hFA);
    for (int k = 0; k < 6; k++) pulse();
    repeat (2) @(negedge clk);
    chk(cnt_o == 8'hFA, "R5 reload value", cnt_o, 8'hFA);
    chk(ovf_seen == 2, "R5 ovf pulse", ovf_seen, 2);
    chk(pin_o == 1'b0, "R9 second toggle", pin_o, 0);

    // R8 pin selection
    wr(2'd1, 4'h3);
    chk(pin_o == 1'b1, "R8 forced high", pin_o, 1);
    wr(2'd1, 4'h2);
    chk(pin_o == 1'b0, "R8 forced low", pin_o, 0);
    wr(2'd1, 4'h0);
    port_i = 1'b0; @(negedge clk);
    chk(pin_o == 1'b0, "R8 port low", pin_o, 0);
    port_i = 1'b1; @(negedge clk);
    chk(pin_o == 1'b1, "R8 port high", pin_o, 1);

    // R1 reset mid-run clears count and selection
    wr(2'd1, 4'h2);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    chk(cnt_o == 8'h00, "R1 reset count", cnt_o, 0);
    chk(pin_o == port_i, "R1 reset pin select", pin_o, port_i);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule